// File: doc/BRIEF.md
# HDLC Receive Deframer with Per-Byte Packet Status

This block receives a serial HDLC bit stream. A clock-enable strobe marks each valid bit. The block finds frame delimiters, removes the zeros the transmitter inserted, assembles bytes least significant bit first and checks the 16-bit frame check sequence. Data bytes go into a small internal receive queue. The two check bytes are consumed but never stored. Every stored byte carries a 3-bit status code and a marker that says whether the byte opens a message.

The host reads through a pop strobe. After each pop, the byte and status outputs show the entry just removed. A look-ahead output shows whether the entry now at the head opens a message. An empty flag tracks the queue occupancy at all times. Each frame ends in exactly one entry that carries its closing status: good, check-sequence failure, abort, overrun or too short. Every earlier byte of that frame carries the in-progress code.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: The pattern 01111110 delimits frames. Repeated delimiters, idle ones between frames and bits seen while hunting for a delimiter store no entry.
- R2: Inside a frame, a 0 that follows five consecutive 1s is deleted. Bytes are assembled least significant bit first from the remaining bits.
- R3: A frame of four or more bytes counts the two check bytes. If it closes byte-aligned and its CRC-16 (polynomial 0x1021 processed LSB first, register preset 0xFFFF) leaves the residue 0xF0B8, all data bytes are stored. The two check bytes are not stored. The last data byte carries status 001 and every other byte carries 000.
- R4: A frame of four or more bytes that closes with a wrong residue, or with a partial byte pending, ends with status 010 on its last data byte.
- R5: A frame that closes with one to three bytes, counting the check bytes, stores exactly one entry. That entry holds the first received byte and carries status 101.
- R6: Seven consecutive 1s abort the frame. If at least one byte was completed, one entry with status 011 is stored. That entry holds the oldest completed byte not yet stored. The receiver then ignores input until the next delimiter.
- R7: A data byte that arrives while the queue holds DEPTH-1 entries is stored with status 100. The rest of that frame is discarded. If the queue is completely full, nothing is stored and the frame is discarded.
- R8: A pop of a non-empty queue loads rd_data and rd_status from the removed entry. A pop while empty changes nothing. After reset both outputs read 0.
- R9: rd_first is high exactly when the queue is non-empty and its head entry is the first stored byte of a frame.
- R10: fifo_empty is high whenever the queue holds no entry, including after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Strobe qualifying bit_in for one cycle |
| bit_in | input | 1 | Serial line bit |
| pop | input | 1 | Remove the head entry (ignored when empty) |
| fifo_empty | output | 1 | Queue holds no entry |
| rd_data | output | 8 | Data byte of the last popped entry |
| rd_status | output | 3 | Status code of the last popped entry |
| rd_first | output | 1 | Head entry opens a message |

## Verification
A wrong internal state surfaces at the ports in different places. A broken zero-deletion or delimiter count corrupts data bytes. A stale check register changes the closing status code. Both become visible on the pop that follows the frame's end. Hold-register or byte-count errors move the status onto the wrong byte or misplace the opening marker, and rd_first shows this a cycle before the pop. Occupancy errors show at once on fifo_empty. A missing overrun stop shows up as extra entries after the 100-coded one.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    localparam int FLAG_ONES  = 6;              // ones inside a delimiter
    localparam int FLAG_DELAY = FLAG_ONES + 1;  // accepted bits of a delimiter
    localparam int FCS_BYTES  = 2;
    localparam int HOLD_BYTES = FCS_BYTES + 1;  // check bytes plus last data byte

    localparam logic [15:0] FCS_POLY_REFL    = 16'h8408;
    localparam logic [15:0] FCS_PRESET       = 16'hFFFF;
    localparam logic [15:0] FCS_GOOD_RESIDUE = 16'hF0B8;

    typedef enum logic [2:0] {
        ST_BUSY    = 3'b000,
        ST_GOOD    = 3'b001,
        ST_FCS_BAD = 3'b010,
        ST_ABORT   = 3'b011,
        ST_OVERRUN = 3'b100,
        ST_SHORT   = 3'b101
    } pkt_status_e;

    typedef struct packed {
        logic        first;
        pkt_status_e status;
        logic [7:0]  data;
    } rx_entry_t;

    // one LSB-first step of the reflected CRC-16 register
    function automatic logic [15:0] fcs_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return {1'b0, c[15:1]} ^ (fb ? FCS_POLY_REFL : 16'h0000);
    endfunction

endpackage

// File: rtl/hdlc_rx_bitproc.sv
module hdlc_rx_bitproc
    import hdlc_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic bit_in,
    output logic dat_vld,
    output logic dat_bit,
    output logic flag_hit,
    output logic abort_hit
);

    localparam int ONES_MAX = FLAG_ONES + 1;
    localparam int ONES_W   = $clog2(ONES_MAX + 1);
    localparam int FILL_W   = $clog2(FLAG_DELAY + 1);

    logic [ONES_W-1:0]     ones;
    logic [FLAG_DELAY-1:0] dly;
    logic [FILL_W-1:0]     dfill;
    logic                  stuffed;
    logic                  accept;

    always_comb begin
        flag_hit  = bit_en && !bit_in && (ones == ONES_W'(FLAG_ONES));
        abort_hit = bit_en &&  bit_in && (ones == ONES_W'(FLAG_ONES));
        stuffed   = bit_en && !bit_in && (ones == ONES_W'(FLAG_ONES - 1));
        accept    = bit_en && !flag_hit && !abort_hit && !stuffed;
        dat_vld   = accept && (dfill == FILL_W'(FLAG_DELAY));
        dat_bit   = dly[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ones  <= '0;
            dly   <= '0;
            dfill <= '0;
        end else if (bit_en) begin
            if (bit_in) begin
                if (ones != ONES_W'(ONES_MAX))
                    ones <= ones + 1'b1;
            end else begin
                ones <= '0;
            end
            if (flag_hit || abort_hit) begin
                dfill <= '0;
            end else if (accept) begin
                dly <= {bit_in, dly[FLAG_DELAY-1:1]};
                if (dfill != FILL_W'(FLAG_DELAY))
                    dfill <= dfill + 1'b1;
            end
        end
    end

    AST_FLAG_FLUSH: assert property (@(posedge clk) disable iff (rst)
        flag_hit |=> !dat_vld);   // R1
    AST_ABORT_FLUSH: assert property (@(posedge clk) disable iff (rst)
        abort_hit |=> !dat_vld);  // R6

endmodule

// File: rtl/hdlc_rx_framer.sv
module hdlc_rx_framer
    import hdlc_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_en,
    input  logic      dat_vld,
    input  logic      dat_bit,
    input  logic      flag_hit,
    input  logic      abort_hit,
    input  logic      fifo_full,
    input  logic      fifo_one_left,
    output logic      push,
    output rx_entry_t push_entry
);

    localparam int NB_W   = $clog2(HOLD_BYTES + 2);
    localparam int NB_SAT = HOLD_BYTES + 1;

    logic        active;
    logic [6:0]  sh;
    logic [2:0]  bcnt;
    logic [NB_W-1:0] nb;
    logic [7:0]  hold [HOLD_BYTES];
    logic [15:0] crc;

    logic        byte_done;
    logic [7:0]  new_byte;
    logic [1:0]  oi;
    pkt_status_e end_code;
    logic        data_push_req;

    always_comb begin
        byte_done     = active && dat_vld && (bcnt == 3'd7);
        new_byte      = {dat_bit, sh};
        data_push_req = byte_done && (nb >= NB_W'(HOLD_BYTES));
        if (nb >= NB_W'(HOLD_BYTES))
            oi = 2'(HOLD_BYTES - 1);
        else if (nb == '0)
            oi = 2'd0;
        else
            oi = 2'(nb - 1'b1);

        if (nb <= NB_W'(HOLD_BYTES))
            end_code = ST_SHORT;
        else if (bcnt != 3'd0)
            end_code = ST_FCS_BAD;
        else if (crc == FCS_GOOD_RESIDUE)
            end_code = ST_GOOD;
        else
            end_code = ST_FCS_BAD;

        push              = 1'b0;
        push_entry.first  = (nb <= NB_W'(HOLD_BYTES));
        push_entry.data   = hold[oi];
        push_entry.status = ST_BUSY;
        if (active && flag_hit && nb != '0) begin
            push              = !fifo_full;
            push_entry.status = end_code;
        end else if (active && abort_hit && nb != '0) begin
            push              = !fifo_full;
            push_entry.status = ST_ABORT;
        end else if (data_push_req) begin
            push              = !fifo_full;
            push_entry.status = fifo_one_left ? ST_OVERRUN : ST_BUSY;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            sh     <= '0;
            bcnt   <= '0;
            nb     <= '0;
            crc    <= FCS_PRESET;
            for (int i = 0; i < HOLD_BYTES; i++)
                hold[i] <= '0;
        end else if (flag_hit) begin
            active <= 1'b1;
            bcnt   <= '0;
            nb     <= '0;
            crc    <= FCS_PRESET;
        end else if (abort_hit) begin
            active <= 1'b0;
        end else if (active && dat_vld) begin
            crc <= fcs_step(crc, dat_bit);
            if (bcnt == 3'd7) begin
                bcnt <= '0;
                for (int i = HOLD_BYTES - 1; i > 0; i--)
                    hold[i] <= hold[i-1];
                hold[0] <= new_byte;
                if (nb != NB_W'(NB_SAT))
                    nb <= nb + 1'b1;
                if (data_push_req && (fifo_full || fifo_one_left))
                    active <= 1'b0;
            end else begin
                sh   <= {dat_bit, sh[6:1]};
                bcnt <= bcnt + 1'b1;
            end
        end
    end

    AST_PUSH_ON_BIT: assert property (@(posedge clk) disable iff (rst)
        push |-> bit_en);  // R1
    AST_ABORT_HUNT: assert property (@(posedge clk) disable iff (rst)
        abort_hit |=> !active);  // R6
    AST_OVR_STOP: assert property (@(posedge clk) disable iff (rst)
        (push && push_entry.status == ST_OVERRUN) |=> !active);  // R7

endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
    import hdlc_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  rx_entry_t wr_entry,
    input  logic      rd_en,
    output rx_entry_t rd_entry,
    output logic      empty,
    output logic      full,
    output logic      one_left
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    rx_entry_t       mem [DEPTH];
    logic [AW-1:0]   wptr;
    logic [AW-1:0]   rptr;
    logic [CW-1:0]   count;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        empty    = (count == '0);
        full     = (count == CW'(DEPTH));
        one_left = (count == CW'(DEPTH - 1));
        rd_entry = mem[rptr];
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wptr] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_en) wptr <= ptr_inc(wptr);
            if (rd_en) rptr <= ptr_inc(rptr);
            case ({wr_en, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !full);   // R7
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> !empty);  // R10

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       bit_in,
    input  logic       pop,
    output logic       fifo_empty,
    output logic [7:0] rd_data,
    output logic [2:0] rd_status,
    output logic       rd_first
);

    logic      dat_vld, dat_bit, flag_hit, abort_hit;
    logic      push, q_empty, q_full, q_one_left, pop_go;
    rx_entry_t push_entry, head;

    hdlc_rx_bitproc bitproc_i (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .bit_in   (bit_in),
        .dat_vld  (dat_vld),
        .dat_bit  (dat_bit),
        .flag_hit (flag_hit),
        .abort_hit(abort_hit)
    );

    hdlc_rx_framer framer_i (
        .clk          (clk),
        .rst          (rst),
        .bit_en       (bit_en),
        .dat_vld      (dat_vld),
        .dat_bit      (dat_bit),
        .flag_hit     (flag_hit),
        .abort_hit    (abort_hit),
        .fifo_full    (q_full),
        .fifo_one_left(q_one_left),
        .push         (push),
        .push_entry   (push_entry)
    );

    hdlc_rx_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (push),
        .wr_entry(push_entry),
        .rd_en   (pop_go),
        .rd_entry(head),
        .empty   (q_empty),
        .full    (q_full),
        .one_left(q_one_left)
    );

    always_comb begin
        pop_go     = pop && !q_empty;
        fifo_empty = q_empty;
        rd_first   = !q_empty && head.first;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data   <= '0;
            rd_status <= '0;
        end else if (pop_go) begin
            rd_data   <= head.data;
            rd_status <= head.status;
        end
    end

    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pop && fifo_empty) |=> ($stable(rd_data) && $stable(rd_status)));  // R8

endmodule

// File: tb/hdlc_rx_deframer_tb.sv
module hdlc_rx_deframer_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b1;
    logic       pop = 1'b0;
    logic       fifo_empty;
    logic [7:0] rd_data;
    logic [2:0] rd_status;
    logic       rd_first;

    int errs = 0;
    int checks = 0;
    int tx_ones = 0;
    logic [11:0] exp_q [$];   // {first, status[2:0], data[7:0]}

    always #10 clk = ~clk;   // 50 MHz

    hdlc_rx_deframer #(.DEPTH(16)) dut_i (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in), .pop(pop),
        .fifo_empty(fifo_empty), .rd_data(rd_data), .rd_status(rd_status),
        .rd_first(rd_first)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
        end
    endtask

    task automatic send_raw(input logic b);
        bit_en = 1'b1; bit_in = b;
        @(negedge clk);
        bit_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_flag();
        send_raw(0);
        for (int i = 0; i < 6; i++) send_raw(1);
        send_raw(0);
        tx_ones = 0;
    endtask

    task automatic send_bit_st(input logic b);
        send_raw(b);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin
                send_raw(0);
                tx_ones = 0;
            end
        end else begin
            tx_ones = 0;
        end
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit_st(v[i]);
    endtask

    function automatic logic [15:0] crc_of(input logic [7:0] d[$]);
        logic [15:0] c = 16'hFFFF;
        foreach (d[k]) begin
            for (int i = 0; i < 8; i++) begin
                logic fb = c[0] ^ d[k][i];
                c = c >> 1;
                if (fb) c = c ^ 16'h8408;
            end
        end
        return c;
    endfunction

    // expected entries for a frame that ended after n completed bytes
    task automatic model_end(input logic [7:0] all[$], input int n, input logic [2:0] st);
        int e;
        if (n == 0) return;
        for (int i = 0; i <= n - 4; i++)
            exp_q.push_back({(i == 0), 3'b000, all[i]});
        e = (n >= 3) ? n - 3 : 0;
        exp_q.push_back({(e == 0), st, all[e]});
    endtask

    task automatic send_frame(input logic [7:0] d[$], input bit bad_fcs, input int extra_bits);
        logic [7:0]  all[$];
        logic [15:0] f;
        logic [2:0]  st;
        all = d;
        f = ~crc_of(d);
        if (bad_fcs) f = f ^ 16'h0100;
        all.push_back(f[7:0]);
        all.push_back(f[15:8]);
        send_flag();
        foreach (all[i]) send_byte(all[i]);
        for (int i = 0; i < extra_bits; i++) send_bit_st(1'b0);
        send_flag();
        if (all.size() <= 3)               st = 3'b101;
        else if (extra_bits != 0 || bad_fcs) st = 3'b010;
        else                                 st = 3'b001;
        model_end(all, all.size(), st);
    endtask

    task automatic drain(input string tag);
        int guard = 0;
        logic [11:0] e;
        while (!fifo_empty && guard < 40) begin
            guard++;
            if (exp_q.size() == 0) begin
                chk(0, "R10", "unexpected entry", 1, 0);
                e = '0;
            end else begin
                e = exp_q.pop_front();
            end
            chk(rd_first == e[11], "R9", "rd_first before pop", int'(rd_first), int'(e[11]));
            pop = 1'b1;
            @(negedge clk);
            pop = 1'b0;
            chk(rd_data == e[7:0], tag, "rd_data", int'(rd_data), int'(e[7:0]));
            chk(rd_status == e[10:8], tag, "rd_status", int'(rd_status), int'(e[10:8]));
        end
        chk(exp_q.size() == 0, "R10", "missing entries", exp_q.size(), 0);
        exp_q.delete();
        chk(fifo_empty == 1'b1, "R10", "empty after drain", int'(fifo_empty), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [7:0] d[$];
        logic [7:0] sv_data;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk(fifo_empty == 1'b1, "R10", "empty after reset", int'(fifo_empty), 1);
        chk(rd_data == 8'h00, "R8", "rd_data after reset", int'(rd_data), 0);
        chk(rd_status == 3'b000, "R8", "rd_status after reset", int'(rd_status), 0);
        chk(rd_first == 1'b0, "R9", "rd_first after reset", int'(rd_first), 0);

        // R1: delimiters, idle ones and garbage while hunting
        for (int i = 0; i < 4; i++) send_flag();
        for (int i = 0; i < 20; i++) send_raw(1);
        for (int i = 0; i < 11; i++) send_raw(i[0]);
        send_flag(); send_flag();
        repeat (4) @(negedge clk);
        chk(fifo_empty == 1'b1, "R1", "no entry from idle/flags", int'(fifo_empty), 1);

        // R2: stuffing-heavy payload
        d = '{8'h7E, 8'hFF, 8'h3E, 8'hF8, 8'h1F};
        send_frame(d, 0, 0);
        drain("R2");

        // R3: two good frames queued, minimal good frame second
        d = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC};
        send_frame(d, 0, 0);
        d = '{8'hA5, 8'h5A};
        send_frame(d, 0, 0);
        drain("R3");

        // R4: wrong check value, then misaligned close
        d = '{8'h01, 8'h02, 8'h03};
        send_frame(d, 1, 0);
        d = '{8'hC3, 8'h3C};
        send_frame(d, 0, 3);
        drain("R4");

        // R5: too short, with one data byte and with none
        d = '{8'h5C};
        send_frame(d, 0, 0);
        d = '{};
        send_frame(d, 0, 0);
        drain("R5");

        // R6: abort after five bytes, last byte ends in 0
        d = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
        send_flag();
        foreach (d[i]) send_byte(d[i]);
        for (int i = 0; i < 10; i++) send_raw(1);
        send_flag();
        model_end(d, 4, 3'b011);   // last byte incomplete at abort
        drain("R6");

        // R7: overrun with 16-entry queue and no pops
        d = '{};
        for (int i = 0; i < 22; i++) d.push_back(8'(8'h10 + i));
        send_frame(d, 0, 0);
        exp_q.delete();
        for (int i = 0; i < 15; i++) exp_q.push_back({(i == 0), 3'b000, d[i]});
        exp_q.push_back({1'b0, 3'b100, d[15]});
        drain("R7");

        // R8: pop while empty changes nothing
        sv_data = rd_data;
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        @(negedge clk);
        chk(rd_status == 3'b100, "R8", "status held on empty pop", int'(rd_status), 4);
        chk(rd_data == sv_data, "R8", "data held on empty pop", int'(rd_data), int'(sv_data));
        chk(fifo_empty == 1'b1, "R10", "still empty", int'(fifo_empty), 1);

        // recovery after overrun
        d = '{8'h66, 8'h77};
        send_frame(d, 0, 0);
        drain("R3");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule